// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake-Up Sequencer

This block decides when the signal path of a low-power radio receiver is powered. It spends most of its time asleep, with only its own timer counting base clock cycles. When the programmed sleep interval runs out it enables the signal path, waits a fixed settling time, and then hands control to an external edge-timing checker that judges whether a valid transmitter is on the air.

If the checker reports success, the block stays in its receiving state with the signal path permanently on, until an explicit off command sends it back to sleep. If the checker reports failure, the block goes straight back to sleep and the cycle repeats. The sleep interval is the product of a 5-bit sleep word, an extension multiplier of 1 or 8, and a tick length (1024 base cycles by default). The settings are sampled when a sleep period begins, so software can rewrite them at any time without disturbing the interval already in progress.

Top module: `poll_wake_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `phase` is 0, and `path_en` and `active` are both 0.
- R2: `phase` codes are 0 = sleep, 1 = start-up, 2 = bit-check, 3 = receiving; `path_en` and `active` are 0 in sleep and 1 in the other three phases.
- R3: With `poll_en` high, sleep lasts S × M × TICK_DIV clock cycles, where S is the captured sleep word and M is XFACT (default 8) when the captured extension bit is 1 and 1 when it is 0.
- R4: A captured sleep word of 0 makes sleep last exactly one cycle.
- R5: Start-up lasts STARTUP_CYCLES clock cycles and is always followed by bit-check.
- R6: Bit-check holds until `chk_done` is high; the next cycle is receiving when `chk_ok` was 1 and sleep when it was 0.
- R7: Receiving holds for as long as `off_cmd` is low; a cycle with `off_cmd` high makes the next cycle sleep.
- R8: `off_cmd` outside receiving and `chk_done` outside bit-check have no effect on the phase sequence or its timing.
- R9: While `poll_en` is low the block stays in sleep with its timer restarted; the full sleep interval is counted from the first cycle `poll_en` is high again.
- R10: The sleep word and extension bit are sampled on entry to sleep, during reset and while `poll_en` is low; changes made during a running sleep interval do not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sleep | input | 5 | Sleep word S |
| cfg_xsel | input | 1 | Extension select: 1 gives multiplier XFACT, 0 gives 1 |
| poll_en | input | 1 | Polling enable; low holds the block asleep |
| chk_done | input | 1 | Strobe from the edge-timing checker: verdict valid |
| chk_ok | input | 1 | Verdict of the checker, 1 = valid signal |
| off_cmd | input | 1 | Off command, leaves receiving |
| path_en | output | 1 | Enable for the signal-processing circuits |
| active | output | 1 | Activity status output |
| phase | output | 2 | Current phase code |

## Verification
The embedded assertions watch every cycle for the phase transitions that follow from a single cycle of inputs: start-up expiring into bit-check, a failed verdict or an off command returning to sleep, receiving holding without an off command, a disabled poll holding sleep, the captured settings staying frozen during an enabled sleep, and the timer never running past its limit. The lengths of whole intervals, the multiplier arithmetic including the zero sleep word, and the immunity of a running interval to rewritten settings only show up across the bench's scenarios, which measure each sleep and start-up span end to end and compare it with the value computed from the captured settings.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        PH_SLEEP = 2'd0,
        PH_START = 2'd1,
        PH_CHECK = 2'd2,
        PH_RX    = 2'd3
    } pw_phase_e;
endpackage

// File: rtl/pw_sleep_calc.sv
module pw_sleep_calc #(
    parameter int SLEEP_W  = 5,
    parameter int XFACT    = 8,
    parameter int TICK_DIV = 1024,
    parameter int CNT_W    = 18
) (
    input  logic [SLEEP_W-1:0] sleep_word,
    input  logic               xsel,
    output logic [CNT_W-1:0]   limit
);
    localparam bit TICK_POW2 = (TICK_DIV & (TICK_DIV - 1)) == 0;
    localparam int TICK_SH   = $clog2(TICK_DIV);

    logic [CNT_W-1:0] units;
    logic [CNT_W-1:0] prod;

    always_comb begin
        if (xsel) units = CNT_W'(sleep_word) * CNT_W'(XFACT);
        else      units = CNT_W'(sleep_word);
    end

    generate
        if (TICK_POW2) begin : g_shift
            assign prod = units << TICK_SH;
        end else begin : g_mult
            assign prod = units * CNT_W'(TICK_DIV);
        end
    endgenerate

    assign limit = (sleep_word == '0) ? CNT_W'(1) : prod;
endmodule

// File: rtl/pw_phase_timer.sv
module pw_phase_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == limit - CNT_W'(1));

    // R3 R5: the phase timer never runs past the active limit
    p_no_overrun_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit);
endmodule

// File: rtl/poll_wake_seq.sv
module poll_wake_seq #(
    parameter int SLEEP_W        = 5,
    parameter int XFACT          = 8,
    parameter int TICK_DIV       = 1024,
    parameter int STARTUP_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SLEEP_W-1:0] cfg_sleep,
    input  logic               cfg_xsel,
    input  logic               poll_en,
    input  logic               chk_done,
    input  logic               chk_ok,
    input  logic               off_cmd,
    output logic               path_en,
    output logic               active,
    output logic [1:0]         phase
);
    import pw_pkg::*;

    localparam int SLEEP_MAX = (1 << SLEEP_W) - 1;
    localparam int SPAN_MAX  = SLEEP_MAX * XFACT * TICK_DIV + STARTUP_CYCLES;
    localparam int CNT_W     = $clog2(SPAN_MAX + 1);

    typedef struct packed {
        pw_phase_e          ph;
        logic [SLEEP_W-1:0] sl;
        logic               xs;
    } seq_t;

    seq_t             s_d, s_q;
    logic             tmr_clr;
    logic             tmr_done;
    logic [CNT_W-1:0] sleep_lim;
    logic [CNT_W-1:0] tmr_lim;

    pw_sleep_calc #(
        .SLEEP_W (SLEEP_W),
        .XFACT   (XFACT),
        .TICK_DIV(TICK_DIV),
        .CNT_W   (CNT_W)
    ) u_calc (
        .sleep_word(s_q.sl),
        .xsel      (s_q.xs),
        .limit     (sleep_lim)
    );

    assign tmr_lim = (s_q.ph == PH_SLEEP) ? sleep_lim : CNT_W'(STARTUP_CYCLES);

    pw_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .limit(tmr_lim),
        .done (tmr_done)
    );

    always_comb begin
        s_d     = s_q;
        tmr_clr = 1'b0;
        case (s_q.ph)
            PH_SLEEP: begin
                if (!poll_en) begin
                    tmr_clr = 1'b1;
                    s_d.sl  = cfg_sleep;
                    s_d.xs  = cfg_xsel;
                end else if (tmr_done) begin
                    tmr_clr = 1'b1;
                    s_d.ph  = PH_START;
                end
            end
            PH_START: begin
                if (tmr_done) begin
                    tmr_clr = 1'b1;
                    s_d.ph  = PH_CHECK;
                end
            end
            PH_CHECK: begin
                tmr_clr = 1'b1;
                if (chk_done) begin
                    if (chk_ok) begin
                        s_d.ph = PH_RX;
                    end else begin
                        s_d.ph = PH_SLEEP;
                        s_d.sl = cfg_sleep;
                        s_d.xs = cfg_xsel;
                    end
                end
            end
            default: begin
                tmr_clr = 1'b1;
                if (off_cmd) begin
                    s_d.ph = PH_SLEEP;
                    s_d.sl = cfg_sleep;
                    s_d.xs = cfg_xsel;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph <= PH_SLEEP;
            s_q.sl <= cfg_sleep;
            s_q.xs <= cfg_xsel;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase   = s_q.ph;
    assign path_en = (s_q.ph != PH_SLEEP);
    assign active  = (s_q.ph != PH_SLEEP);

    // R5: an expiring start-up always leads into bit-check
    p_start_to_check_r5: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_START && tmr_done) |=> (s_q.ph == PH_CHECK));

    // R6: a failed verdict returns to sleep
    p_fail_to_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_CHECK && chk_done && !chk_ok) |=> (s_q.ph == PH_SLEEP));

    // R7: receiving holds without an off command
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_RX && !off_cmd) |=> (s_q.ph == PH_RX));

    // R7: off command leaves receiving
    p_off_to_sleep_r7: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_RX && off_cmd) |=> (s_q.ph == PH_SLEEP));

    // R9: disabled polling keeps the block asleep
    p_hold_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_SLEEP && !poll_en) |=> (s_q.ph == PH_SLEEP));

    // R10: captured settings stay frozen during an enabled sleep
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_SLEEP && poll_en) |=> ($stable(s_q.sl) && $stable(s_q.xs)));
endmodule

// File: tb/sim_poll_wake_seq.sv
module sim_poll_wake_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 4;
    localparam int XF         = 8;
    localparam int STARTUP    = 6;
    localparam int ROUNDS     = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] cfg_sleep;
    logic       cfg_xsel;
    logic       poll_en;
    logic       chk_done;
    logic       chk_ok;
    logic       off_cmd;
    logic       path_en;
    logic       active;
    logic [1:0] phase;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int cap_s;
    int cap_x;

    always #(CLK_PERIOD / 2) clk = ~clk;

    poll_wake_seq #(
        .SLEEP_W(5), .XFACT(XF), .TICK_DIV(TICK), .STARTUP_CYCLES(STARTUP)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_sleep(cfg_sleep), .cfg_xsel(cfg_xsel),
        .poll_en(poll_en), .chk_done(chk_done), .chk_ok(chk_ok),
        .off_cmd(off_cmd), .path_en(path_en), .active(active), .phase(phase)
    );

    function automatic int exp_sleep(int s, int x);
        if (s == 0) return 1;
        return s * (x != 0 ? XF : 1) * TICK;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(int s, int x);
        cfg_sleep = 5'(s);
        cfg_xsel  = x[0];
        cap_s     = s;
        cap_x     = x & 1;
    endtask

    // Sleep is current at this negedge; measure it, disturbing settings
    task automatic measure_sleep(bit gap);
        int n = 0;
        if (gap) begin
            poll_en = 1'b0;
            set_cfg($urandom_range(0, 31), $urandom_range(0, 1));
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk("R9 hold", int'(phase), 0);
            end
            poll_en = 1'b1;
        end
        chk("R2 sleep outputs", int'({path_en, active}), 0);
        while (phase == 2'd0 && n < 20000) begin
            n++;
            if (n == 2) begin
                cfg_sleep = 5'($urandom_range(0, 31));
                cfg_xsel  = 1'($urandom_range(0, 1));
            end
            if (n == 3 && (n % 2) == 1) chk_done = 1'b1;
            @(negedge clk);
            chk_done = 1'b0;
        end
        chk(cap_s == 0 ? "R4 R10 sleep length" : "R3 R10 sleep length",
            n, exp_sleep(cap_s, cap_x));
    endtask

    task automatic run_round(bit gap);
        int n = 0;
        int w;
        bit ok;
        measure_sleep(gap);
        chk("R2 start outputs", int'({path_en, active}), 3);
        while (phase == 2'd1 && n < 1000) begin
            n++;
            off_cmd  = 1'($urandom_range(0, 1));
            chk_done = 1'($urandom_range(0, 1));
            @(negedge clk);
            off_cmd  = 1'b0;
            chk_done = 1'b0;
        end
        chk("R5 R8 start length", n, STARTUP);
        chk("R5 check follows", int'(phase), 2);
        w = $urandom_range(0, 5);
        for (int k = 0; k < w; k++) begin
            off_cmd = 1'($urandom_range(0, 1));
            @(negedge clk);
            off_cmd = 1'b0;
            chk("R6 R8 check holds", int'(phase), 2);
        end
        set_cfg($urandom_range(0, 31), $urandom_range(0, 1));
        if ($urandom_range(0, 7) == 0) set_cfg(0, $urandom_range(0, 1));
        ok       = 1'($urandom_range(0, 1));
        chk_done = 1'b1;
        chk_ok   = ok;
        @(negedge clk);
        chk_done = 1'b0;
        chk_ok   = $urandom_range(0, 1) != 0;
        chk("R6 verdict", int'(phase), ok ? 3 : 0);
        if (ok) begin
            w = $urandom_range(1, 6);
            for (int k = 0; k < w; k++) begin
                chk_done = 1'($urandom_range(0, 1));
                @(negedge clk);
                chk_done = 1'b0;
                chk("R7 R8 rx holds", int'(phase), 3);
                chk("R2 rx outputs", int'({path_en, active}), 3);
            end
            set_cfg($urandom_range(0, 31), $urandom_range(0, 1));
            off_cmd = 1'b1;
            @(negedge clk);
            off_cmd = 1'b0;
            chk("R7 off", int'(phase), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4321));
        rst = 1'b1; poll_en = 1'b1; chk_done = 1'b0; chk_ok = 1'b0; off_cmd = 1'b0;
        set_cfg(0, 0);
        repeat (3) @(negedge clk);
        chk("R1 reset phase", int'(phase), 0);
        chk("R1 reset outputs", int'({path_en, active}), 0);
        rst = 1'b0;
        chk("R1 first cycle", int'(phase), 0);
        run_round(1'b0);
        set_cfg(31, 1);
        run_round(1'b1);
        for (int r = 0; r < ROUNDS; r++) run_round(($urandom_range(0, 3) == 0));
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule